// File: doc/BRIEF.md
# Smartcard Block Reception Monitor

This block sits beside a smartcard receiver running in block mode. It counts the characters of the block being received. It raises an end-of-block flag once the count reaches the block length plus four. The length is held in an 8-bit register that software fills from the block's own third byte, the prologue length byte. The count is held at zero whenever the local transmitter is busy, so each new exchange starts from an empty count.

The block also polices the gap between characters. After the end of each character, a timer is loaded from a programmable register and counts baud ticks down. Software loads this register with the character wait time minus 11. If no new start bit shows up before the timer runs out, a sticky timeout flag is raised. A block whose length byte was wrong therefore ends in a timeout rather than an end-of-block event. Both flags stay set until a one-cycle clear pulse, and each drives an interrupt request gated by its own enable.

Top module: `sc_blk_monitor`

## Requirements
- R1: After reset both flags, both interrupt requests and the character count are 0.
- R2: Each `rx_done` pulse while `tx_active` is low adds one to `char_count`.
- R3: While `tx_active` is high, `char_count` is 0 on the following cycle and `rx_done` pulses do not raise it.
- R4: `eob_flag` sets on the `rx_done` pulse that brings `char_count` to `blk_len + 4`. With `blk_len` = 0 this is the 4th character.
- R5: The length comparison always uses the present `blk_len`. A length preset to 0xFF and rewritten after the third character ends the block at the rewritten length.
- R6: With `rt_value` = N ≥ 1, `rt_flag` sets after the Nth `baud_tick` following an `rx_end` that is not followed by `rx_start`. With N = 0 it sets after the first tick.
- R7: An `rx_start` pulse stops a running wait timer with no flag. The next `rx_end` reloads the timer for a full period.
- R8: The wait timer does not run before the first character of a block has been received (count 0 and no `rx_done`). It is also stopped whenever `tx_active` is high.
- R9: Each flag stays set until its clear pulse (`rt_clr` / `eob_clr`). A set event in the same cycle as a clear leaves the flag set.
- R10: `rt_irq` equals `rt_flag` AND `rt_ie`, and `eob_irq` equals `eob_flag` AND `eob_ie`.
- R11: `char_count` saturates at its maximum value (511 by default) instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle strobe per baud time |
| rx_start | input | 1 | Start bit of a new character detected |
| rx_done | input | 1 | A character has been received |
| rx_end | input | 1 | End of the current character (stop bit finished) |
| tx_active | input | 1 | Transmitter busy; clears the count and stops the timer |
| rt_value | input | RT_W | Wait period in baud ticks (character wait time minus 11) |
| blk_len | input | LEN_W | Block length byte taken from the prologue |
| rt_ie | input | 1 | Timeout interrupt enable |
| eob_ie | input | 1 | End-of-block interrupt enable |
| rt_clr | input | 1 | Clear pulse for the timeout flag |
| eob_clr | input | 1 | Clear pulse for the end-of-block flag |
| rt_flag | output | 1 | Sticky inter-character timeout flag |
| eob_flag | output | 1 | Sticky end-of-block flag |
| rt_irq | output | 1 | Timeout interrupt request |
| eob_irq | output | 1 | End-of-block interrupt request |
| char_count | output | LEN_W+1 | Characters received in the current block |

## Verification
The length logic is tested three ways. A block uses a length preset to the maximum and then rewritten after the third byte. A block uses a zero length. A long run with no transmit activity drives the count into saturation. Together these separate a comparison made against the live register from one made against a latched value, and show where the event lands against the count. The wait timer is run to expiry with a mid-range period and with a zero period. It is also cut short by a start bit and then reloaded, and it is given an end-of-character with no character received. This separates correct reload and cancel behaviour from off-by-one expiry and from arming while idle.

// File: rtl/sc_blk_pkg.sv
package sc_blk_pkg;
    // Default widths shared by the monitor and its parts
    localparam int SC_LEN_W  = 8;
    localparam int SC_RT_W   = 24;
    // Prologue (3 bytes) plus epilogue (1 byte) outside the length byte
    localparam int SC_FRAME_OVERHEAD = 4;
endpackage

// File: rtl/sc_cwt_timer.sv
module sc_cwt_timer #(
    parameter int RT_W = sc_blk_pkg::SC_RT_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            baud_tick,
    input  logic            rx_start,
    input  logic            rx_end,
    input  logic            arm_ok,
    input  logic            tx_active,
    input  logic [RT_W-1:0] rt_value,
    output logic            expire
);
    typedef struct packed {
        logic            armed;
        logic [RT_W-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        expire = 1'b0;
        if (tx_active) begin
            s_d.armed = 1'b0;
        end else if (rx_end && arm_ok) begin
            s_d.armed = 1'b1;
            s_d.cnt   = rt_value;
        end else if (rx_start) begin
            s_d.armed = 1'b0;
        end else if (s_q.armed && baud_tick) begin
            if (s_q.cnt <= RT_W'(1)) begin
                expire    = 1'b1;
                s_d.armed = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - RT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R6: expiry only from a running timer
    a_r6_expire_when_armed: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> s_q.armed);
    // R7: a start bit without an end-of-character stops the timer
    a_r7_start_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_start && !rx_end) |=> !s_q.armed);
    // R8: transmit activity stops the timer
    a_r8_tx_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |=> !s_q.armed);
endmodule

// File: rtl/sc_blk_len_counter.sv
module sc_blk_len_counter #(
    parameter int LEN_W = sc_blk_pkg::SC_LEN_W,
    parameter int CNT_W = LEN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_done,
    input  logic             tx_active,
    input  logic [LEN_W-1:0] blk_len,
    output logic [CNT_W-1:0] count,
    output logic             blk_end
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] OVERHEAD = CNT_W'(sc_blk_pkg::SC_FRAME_OVERHEAD);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t s_d, s_q;
    logic [CNT_W-1:0] target;
    logic [CNT_W-1:0] next_cnt;

    always_comb begin
        s_d      = s_q;
        target   = CNT_W'(blk_len) + OVERHEAD;
        next_cnt = s_q.cnt + CNT_W'(1);
        blk_end  = 1'b0;
        if (tx_active) begin
            s_d.cnt = '0;
        end else if (rx_done && s_q.cnt != CNT_MAX) begin
            s_d.cnt = next_cnt;
            blk_end = (next_cnt == target);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count = s_q.cnt;

    // R2: one increment per received character
    a_r2_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !tx_active && s_q.cnt != CNT_MAX) |=> s_q.cnt == $past(s_q.cnt) + CNT_W'(1));
    // R3: transmit activity holds the count at zero
    a_r3_tx_clears: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |=> s_q.cnt == '0);
    // R11: no wrap at the top
    a_r11_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == CNT_MAX && !tx_active) |=> s_q.cnt == CNT_MAX);
endmodule

// File: rtl/sc_sticky_flag.sv
module sc_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic ie,
    output logic flag,
    output logic irq
);
    typedef struct packed {
        logic flag;
    } flg_t;

    flg_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (set)      s_d.flag = 1'b1;
        else if (clr) s_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flag = s_q.flag;
    assign irq  = s_q.flag & ie;

    // R9: flag holds without a clear pulse
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.flag && !clr) |=> s_q.flag);
    // R9: a set event wins over a simultaneous clear
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> s_q.flag);
    // R10: no request without an enable
    a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |-> !irq);
endmodule

// File: rtl/sc_blk_monitor.sv
module sc_blk_monitor #(
    parameter int LEN_W = sc_blk_pkg::SC_LEN_W,
    parameter int RT_W  = sc_blk_pkg::SC_RT_W,
    localparam int CNT_W = LEN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_tick,
    input  logic             rx_start,
    input  logic             rx_done,
    input  logic             rx_end,
    input  logic             tx_active,
    input  logic [RT_W-1:0]  rt_value,
    input  logic [LEN_W-1:0] blk_len,
    input  logic             rt_ie,
    input  logic             eob_ie,
    input  logic             rt_clr,
    input  logic             eob_clr,
    output logic             rt_flag,
    output logic             eob_flag,
    output logic             rt_irq,
    output logic             eob_irq,
    output logic [CNT_W-1:0] char_count
);
    logic             blk_end;
    logic             expire;
    logic             arm_ok;
    logic [CNT_W-1:0] cnt;

    sc_blk_len_counter #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .tx_active(tx_active),
        .blk_len(blk_len), .count(cnt), .blk_end(blk_end)
    );

    // Timer only runs once the block has at least one received character
    assign arm_ok = (cnt != '0) || rx_done;

    sc_cwt_timer #(.RT_W(RT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_start(rx_start),
        .rx_end(rx_end), .arm_ok(arm_ok), .tx_active(tx_active),
        .rt_value(rt_value), .expire(expire)
    );

    sc_sticky_flag u_rt_flag (
        .clk(clk), .rst_n(rst_n), .set(expire), .clr(rt_clr), .ie(rt_ie),
        .flag(rt_flag), .irq(rt_irq)
    );

    sc_sticky_flag u_eob_flag (
        .clk(clk), .rst_n(rst_n), .set(blk_end), .clr(eob_clr), .ie(eob_ie),
        .flag(eob_flag), .irq(eob_irq)
    );

    assign char_count = cnt;

    // R4: end of block only on a received character outside transmit
    a_r4_eob_on_char: assert property (@(posedge clk) disable iff (!rst_n)
        blk_end |-> (rx_done && !tx_active));
    // R8: no timeout while the count is empty and no character arrives
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !rx_done) |-> !expire);
endmodule

// File: tb/sim_sc_blk_monitor.sv
module sim_sc_blk_monitor;
    localparam int LEN_W = 8;
    localparam int RT_W  = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic baud_tick = 0, rx_start = 0, rx_done = 0, rx_end = 0, tx_active = 0;
    logic [RT_W-1:0]  rt_value = '0;
    logic [LEN_W-1:0] blk_len = '0;
    logic rt_ie = 0, eob_ie = 0, rt_clr = 0, eob_clr = 0;
    logic rt_flag, eob_flag, rt_irq, eob_irq;
    logic [LEN_W:0] char_count;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sc_blk_monitor #(.LEN_W(LEN_W), .RT_W(RT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_start(rx_start),
        .rx_done(rx_done), .rx_end(rx_end), .tx_active(tx_active),
        .rt_value(rt_value), .blk_len(blk_len), .rt_ie(rt_ie), .eob_ie(eob_ie),
        .rt_clr(rt_clr), .eob_clr(eob_clr), .rt_flag(rt_flag), .eob_flag(eob_flag),
        .rt_irq(rt_irq), .eob_irq(eob_irq), .char_count(char_count)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic send_char();
        rx_start = 1; cyc(); rx_start = 0;
        rx_done = 1; rx_end = 1; cyc(); rx_done = 0; rx_end = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            baud_tick = 1; cyc(); baud_tick = 0; cyc();
        end
    endtask

    task automatic tx_pulse();
        tx_active = 1; cyc(); tx_active = 0;
    endtask

    task automatic clear_flags();
        rt_clr = 1; eob_clr = 1; cyc(); rt_clr = 0; eob_clr = 0;
    endtask

    task automatic t_reset();
        chk("R1 rt_flag", rt_flag, 0);
        chk("R1 eob_flag", eob_flag, 0);
        chk("R1 irqs", {rt_irq, eob_irq}, 0);
        chk("R1 count", char_count, 0);
    endtask

    task automatic t_count_and_rewrite();
        tx_pulse(); clear_flags();
        blk_len = 8'hFF; eob_ie = 1;
        for (int i = 0; i < 3; i++) send_char();
        chk("R2 count after 3", char_count, 3);
        chk("R5 no eob at 3", eob_flag, 0);
        blk_len = 8'd2;
        send_char(); send_char();
        chk("R5 count 5", char_count, 5);
        chk("R5 no eob at 5", eob_flag, 0);
        send_char();
        chk("R5 eob at 6", eob_flag, 1);
        chk("R10 eob_irq on", eob_irq, 1);
        eob_ie = 0; #1;
        chk("R10 eob_irq gated", eob_irq, 0);
        clear_flags();
        chk("R9 eob cleared", eob_flag, 0);
    endtask

    task automatic t_tx_hold();
        tx_pulse();
        chk("R3 count cleared", char_count, 0);
        tx_active = 1; rx_done = 1; cyc(); cyc(); rx_done = 0; tx_active = 0;
        chk("R3 rx_done ignored in tx", char_count, 0);
    endtask

    task automatic t_len_zero();
        tx_pulse(); clear_flags();
        blk_len = 8'd0;
        for (int i = 0; i < 3; i++) send_char();
        chk("R4 no eob at 3", eob_flag, 0);
        send_char();
        chk("R4 eob at 4th", eob_flag, 1);
    endtask

    task automatic t_set_wins();
        tx_pulse(); clear_flags();
        blk_len = 8'd0;
        for (int i = 0; i < 3; i++) send_char();
        rx_start = 1; cyc(); rx_start = 0;
        rx_done = 1; rx_end = 1; eob_clr = 1; cyc();
        rx_done = 0; rx_end = 0; eob_clr = 0;
        chk("R9 set beats clear", eob_flag, 1);
        cyc();
        chk("R9 stays set", eob_flag, 1);
        clear_flags();
        chk("R9 cleared", eob_flag, 0);
    endtask

    task automatic t_timeout();
        tx_pulse(); clear_flags();
        rt_value = 24'd3; rt_ie = 1;
        send_char();
        ticks(2);
        chk("R6 no timeout after 2", rt_flag, 0);
        ticks(1);
        chk("R6 timeout after 3", rt_flag, 1);
        chk("R10 rt_irq on", rt_irq, 1);
        rt_ie = 0; #1;
        chk("R10 rt_irq gated", rt_irq, 0);
        clear_flags();
        rt_value = 24'd0;
        send_char();
        ticks(1);
        chk("R6 zero period first tick", rt_flag, 1);
        clear_flags();
    endtask

    task automatic t_cancel();
        tx_pulse(); clear_flags();
        rt_value = 24'd3;
        send_char();
        ticks(2);
        rx_start = 1; cyc(); rx_start = 0;
        ticks(5);
        chk("R7 start cancels", rt_flag, 0);
        rx_done = 1; rx_end = 1; cyc(); rx_done = 0; rx_end = 0;
        ticks(2);
        chk("R7 reload full period", rt_flag, 0);
        ticks(1);
        chk("R7 reloaded expiry", rt_flag, 1);
        clear_flags();
    endtask

    task automatic t_idle();
        tx_pulse(); clear_flags();
        rt_value = 24'd2;
        rx_end = 1; cyc(); rx_end = 0;
        ticks(6);
        chk("R8 idle no timeout", rt_flag, 0);
        send_char();
        tx_active = 1;
        ticks(4);
        tx_active = 0;
        chk("R8 tx stops timer", rt_flag, 0);
    endtask

    task automatic t_saturate();
        tx_pulse(); clear_flags();
        blk_len = 8'hFF;
        rt_value = 24'd1000;
        rx_done = 1;
        for (int i = 0; i < 515; i++) cyc();
        rx_done = 0;
        chk("R11 saturated", char_count, 511);
        tx_pulse();
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        t_reset();
        t_count_and_rewrite();
        t_tx_hold();
        t_len_zero();
        t_set_wins();
        t_timeout();
        t_cancel();
        t_idle();
        t_saturate();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule